// File: doc/BRIEF.md
# SPI Master Bit-Rate Generator

This block derives the serial clock timing of an SPI master from the bus clock. It has two stages in series. A linear prescaler divides by 1 to 8. A power-of-two rate divider then divides by 2 to 512. The overall divisor is the product of the two. From the bus clock the block produces a one-cycle strobe at every point where the serial clock should change level, and it also gives the divided clock level itself. A shift engine downstream uses the strobe to move data and to drive the serial clock pin. Polarity, phase and shifting are left to that engine.

The enable input holds both counters cleared while it is low. The first strobe therefore arrives one full half-period after the enable rises. The two select fields are captured while the block is idle and again each time the counters complete a half-period. A change made while a transfer is running therefore never shortens or stretches the half-period already in progress.

Top module: `spi_bitrate_gen`

## Requirements
- R1: The prescale field `presc_sel` (3 bits, value p) multiplies the half-period by p+1, so it divides by 1 to 8.
- R2: The rate field `rate_sel` (4 bits, value r from 0 to 8) divides by 2^(r+1). The strobe `edge_tick` therefore repeats every H = (p+1)*2^r bus cycles, and a full serial clock period is 2H.
- R3: Rate codes 9 to 15 behave exactly like code 8, which gives a half-period of (p+1)*256 cycles.
- R4: With p=0 and r=0 the strobe is high on every cycle and `clk_level` toggles on every cycle, which is a total divide of 2.
- R5: While `run` is low, `edge_tick` stays 0, `clk_level` stays 0, and the counters stay cleared.
- R6: If `run` is first sampled high at rising edge 1, the first strobe is seen just after rising edge H, and the following strobes come every H cycles after that.
- R7: `clk_level` changes on the same edge that raises `edge_tick`. The first strobe after enable drives it to 1, and later strobes alternate it.
- R8: A change to `presc_sel` or `rate_sel` while `run` is high takes effect only after the current half-period ends. The next strobe comes H_old cycles after the previous one, and the strobe after that comes H_new cycles later.
- R9: After a synchronous active-low reset, `edge_tick` and `clk_level` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Enable; low holds the counters cleared |
| presc_sel | input | 3 | Prescale select, divide = value + 1 |
| rate_sel | input | 4 | Rate select, divide = 2^(value+1), codes above 8 treated as 8 |
| edge_tick | output | 1 | One-cycle strobe at each serial clock edge point |
| clk_level | output | 1 | Divided serial clock level, 0 while idle |

## Verification
The bench builds the block with its default parameters: a 3-bit prescale field, a 4-bit rate field and a largest legal rate code of 8. These defaults make the whole legal range reachable. This includes the fastest setting of one cycle per half-period and the slowest setting of 2048 cycles per half-period (p=7, r=8). The reserved codes can be checked against code 8 within a few thousand cycles. Because the half-periods are short at the low settings, the bench can also change the settings in the middle of a half-period and see exactly where the new rate starts.

// File: rtl/spi_brg_pkg.sv
// Package: shared sizing constants for the SPI bit-rate generator.
// Assumes: the rate divider is a power of two whose exponent is the rate code plus one.
package spi_brg_pkg;
    localparam int PRESC_W_DEF   = 3;  // prescale field width
    localparam int RATE_W_DEF    = 4;  // rate field width
    localparam int RATE_CODE_DEF = 8;  // largest legal rate code
endpackage

// File: rtl/spi_brg_cfg.sv
// Module: settings holder. Captures the prescale and rate fields when `load`
// is high and clamps rate codes above RATE_CODE_MAX down to RATE_CODE_MAX.
// Assumes: `load` is high while idle and on the cycle that completes a half-period.
module spi_brg_cfg #(
    parameter int PRESC_W       = spi_brg_pkg::PRESC_W_DEF,
    parameter int RATE_W        = spi_brg_pkg::RATE_W_DEF,
    parameter int RATE_CODE_MAX = spi_brg_pkg::RATE_CODE_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [PRESC_W-1:0] presc_in,
    input  logic [RATE_W-1:0]  rate_in,
    output logic [PRESC_W-1:0] presc_q,
    output logic [RATE_W-1:0]  rate_q
);
    localparam logic [RATE_W-1:0] RATE_CAP = RATE_W'(RATE_CODE_MAX);

    logic [RATE_W-1:0] rate_clamped;

    // Map reserved rate codes onto the largest legal code.
    always_comb begin
        rate_clamped = (rate_in > RATE_CAP) ? RATE_CAP : rate_in;
    end

    // Hold the active settings; replace them only on a load cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            presc_q <= '0;
            rate_q  <= '0;
        end else if (load) begin
            presc_q <= presc_in;
            rate_q  <= rate_clamped;
        end
    end

    // R3: the stored rate code never exceeds the legal maximum.
    a_r3_rate_capped: assert property (@(posedge clk) disable iff (!rst_n)
        rate_q <= RATE_CAP);

    // R8: stored settings change only as the result of a load cycle.
    a_r8_hold_between_loads: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(presc_q) && $stable(rate_q)));
endmodule

// File: rtl/spi_brg_presc.sv
// Module: linear prescaler. It counts bus cycles from 0 up to `limit` and
// raises `wrap` on the last cycle, so it divides by limit+1.
// Assumes: `run` low clears the count.
module spi_brg_presc #(
    parameter int PRESC_W = spi_brg_pkg::PRESC_W_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [PRESC_W-1:0] limit,
    output logic               wrap
);
    logic [PRESC_W-1:0] cnt_q;

    // Flag the final count of each prescaler period.
    always_comb begin
        wrap = run && (cnt_q == limit);
    end

    // Advance the count and restart it after the final count.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (wrap) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R1: the count stays within the active prescale limit.
    a_r1_presc_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= limit);

    // R5: the count is cleared one cycle after an idle cycle.
    a_r5_presc_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));
endmodule

// File: rtl/spi_brg_ratediv.sv
// Module: power-of-two rate divider. It counts prescaler wraps from 0 up to
// 2^code - 1 and raises `half_done` on the last of them, which ends one
// serial half-period.
// Assumes: `code` is at most RATE_CODE_MAX; `run` low clears the count.
module spi_brg_ratediv #(
    parameter int RATE_W        = spi_brg_pkg::RATE_W_DEF,
    parameter int RATE_CODE_MAX = spi_brg_pkg::RATE_CODE_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              step,
    input  logic [RATE_W-1:0] code,
    output logic              half_done
);
    localparam int CNT_W = (RATE_CODE_MAX < 1) ? 1 : RATE_CODE_MAX;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   one_hot;
    logic [CNT_W:0]   mask_full;
    logic [CNT_W-1:0] last_cnt;

    // Terminal count 2^code - 1; the wide intermediate keeps code == CNT_W exact.
    always_comb begin
        one_hot   = {{CNT_W{1'b0}}, 1'b1} << code;
        mask_full = one_hot - 1'b1;
        last_cnt  = mask_full[CNT_W-1:0];
        half_done = step && (cnt_q == last_cnt);
    end

    // Count prescaler wraps and restart at the end of each half-period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (half_done) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R2: the count never passes the terminal count for the active code.
    a_r2_rate_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= last_cnt);

    // R2: the count holds between prescaler wraps.
    a_r2_rate_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !step) |=> $stable(cnt_q));
endmodule

// File: rtl/spi_bitrate_gen.sv
// Module: top of the SPI master bit-rate generator. The settings holder feeds
// the prescaler, whose wraps feed the rate divider. A half-period end gives a
// registered one-cycle edge strobe and toggles the clock level.
// Assumes: synchronous active-low reset; `run` low parks everything at zero.
module spi_bitrate_gen #(
    parameter int PRESC_W       = spi_brg_pkg::PRESC_W_DEF,
    parameter int RATE_W        = spi_brg_pkg::RATE_W_DEF,
    parameter int RATE_CODE_MAX = spi_brg_pkg::RATE_CODE_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [PRESC_W-1:0] presc_sel,
    input  logic [RATE_W-1:0]  rate_sel,
    output logic               edge_tick,
    output logic               clk_level
);
    logic               cfg_load;
    logic [PRESC_W-1:0] presc_act;
    logic [RATE_W-1:0]  rate_act;
    logic               pre_wrap;
    logic               half_done;

    // Capture settings while idle or as a half-period completes.
    always_comb begin
        cfg_load = !run || half_done;
    end

    spi_brg_cfg #(
        .PRESC_W       (PRESC_W),
        .RATE_W        (RATE_W),
        .RATE_CODE_MAX (RATE_CODE_MAX)
    ) cfg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cfg_load),
        .presc_in (presc_sel),
        .rate_in  (rate_sel),
        .presc_q  (presc_act),
        .rate_q   (rate_act)
    );

    spi_brg_presc #(
        .PRESC_W (PRESC_W)
    ) presc_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .limit (presc_act),
        .wrap  (pre_wrap)
    );

    spi_brg_ratediv #(
        .RATE_W        (RATE_W),
        .RATE_CODE_MAX (RATE_CODE_MAX)
    ) rate_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .step      (pre_wrap),
        .code      (rate_act),
        .half_done (half_done)
    );

    // Register the edge strobe and toggle the clock level on each half-period end.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            edge_tick <= 1'b0;
            clk_level <= 1'b0;
        end else begin
            edge_tick <= half_done;
            if (half_done) begin
                clk_level <= !clk_level;
            end
        end
    end

    // R7: every strobe comes with a change of the clock level.
    a_r7_level_flips_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        edge_tick |-> (clk_level != $past(clk_level)));

    // R7: without a strobe the level is held, except when it is parked by idle.
    a_r7_level_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && !edge_tick) |-> $stable(clk_level));

    // R5: an idle cycle leaves strobe and level low on the next cycle.
    a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!edge_tick && !clk_level));
endmodule

// File: tb/spi_bitrate_gen_tb_top.sv
`timescale 1ns/1ps
module spi_bitrate_gen_tb_top;
    typedef struct {
        int cyc;
        bit lvl;
        int req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run = 1'b0;
    logic [2:0] presc_sel = '0;
    logic [3:0] rate_sel = '0;
    logic       edge_tick;
    logic       clk_level;

    int   cyc = 0;
    int   n_checks = 0;
    int   n_fail = 0;
    exp_t exp_q[$];

    spi_bitrate_gen dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .presc_sel (presc_sel),
        .rate_sel  (rate_sel),
        .edge_tick (edge_tick),
        .clk_level (clk_level)
    );

    always #10 clk = ~clk;  // 50 MHz

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    // Monitor: pop one expected strobe for every strobe the design makes.
    always @(negedge clk) begin
        if (rst_n && edge_tick) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R5 unexpected tick", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(cyc == e.cyc, $sformatf("R%0d tick cycle", e.req), cyc, e.cyc);
                check(clk_level == e.lvl, "R7 level at tick", clk_level, e.lvl);
            end
        end
    end

    function automatic int half_of(input int p, input int r);
        int rr;
        rr = (r > 8) ? 8 : r;
        return (p + 1) * (1 << rr);
    endfunction

    task automatic wait_cyc(input int target);
        while (cyc < target) @(negedge clk);
    endtask

    task automatic drain(input string req);
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, req, exp_q.size(), 0);
        exp_q.delete();
    endtask

    // Driver: run one fixed setting for n strobes and queue the expected ones.
    task automatic run_seq(input int p, input int r, input int n, input int req);
        int h;
        int n0;
        @(negedge clk);
        presc_sel = 3'(p);
        rate_sel  = 4'(r);
        run = 1'b0;
        repeat (2) @(negedge clk);
        h = half_of(p, r);
        run = 1'b1;
        n0 = cyc;
        for (int k = 1; k <= n; k++) begin
            exp_t e;
            e.cyc = n0 + k * h;
            e.lvl = k[0];
            e.req = (k == 1) ? 6 : req;
            exp_q.push_back(e);
        end
        wait_cyc(n0 + n * h);
        run = 1'b0;
        drain($sformatf("R%0d missing ticks", req));
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        wait (cyc > 150000);
        check(1'b0, "watchdog", cyc, 150000);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check(edge_tick == 1'b0, "R9 tick in reset", edge_tick, 0);
        check(clk_level == 1'b0, "R9 level in reset", clk_level, 0);
        rst_n = 1'b1;

        // R5: idle with the fastest setting gives no strobe and a low level
        presc_sel = 3'd0;
        rate_sel  = 4'd0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (i % 5 == 0) begin
                check(edge_tick == 1'b0 && clk_level == 1'b0, "R5 idle quiet",
                      {edge_tick, clk_level}, 0);
            end
        end

        // R4: fastest, divide by 2
        run_seq(0, 0, 6, 4);
        // R1: prescale divides linearly
        run_seq(2, 0, 4, 1);
        run_seq(7, 0, 4, 1);
        // R2: power-of-two divider
        run_seq(0, 3, 4, 2);
        run_seq(4, 5, 3, 2);
        // R2: slowest legal setting, half-period 2048
        run_seq(7, 8, 2, 2);
        // R3: reserved codes behave like code 8
        run_seq(1, 15, 2, 3);
        run_seq(0, 9, 2, 3);

        // R8: a mid-period change takes effect only after the current half-period
        begin
            int n0;
            exp_t e;
            @(negedge clk);
            presc_sel = 3'd2;
            rate_sel  = 4'd1;   // H = 6
            repeat (2) @(negedge clk);
            run = 1'b1;
            n0 = cyc;
            e.cyc = n0 + 6;  e.lvl = 1'b1; e.req = 8; exp_q.push_back(e);
            e.cyc = n0 + 10; e.lvl = 1'b0; e.req = 8; exp_q.push_back(e);
            e.cyc = n0 + 14; e.lvl = 1'b1; e.req = 8; exp_q.push_back(e);
            wait_cyc(n0 + 3);
            presc_sel = 3'd0;
            rate_sel  = 4'd2;   // H = 4
            wait_cyc(n0 + 14);
            run = 1'b0;
            drain("R8 missing ticks");
        end

        // R5: lowering run mid-period restarts cleanly with a full half-period
        begin
            int n0;
            exp_t e;
            @(negedge clk);
            presc_sel = 3'd3;
            rate_sel  = 4'd0;   // H = 4
            repeat (2) @(negedge clk);
            run = 1'b1;
            n0 = cyc;
            wait_cyc(n0 + 2);
            run = 1'b0;
            @(negedge clk);
            check(clk_level == 1'b0, "R5 level after stop", clk_level, 0);
            run = 1'b1;
            n0 = cyc;
            e.cyc = n0 + 4; e.lvl = 1'b1; e.req = 6; exp_q.push_back(e);
            wait_cyc(n0 + 4);
            run = 1'b0;
            drain("R6 missing tick after restart");
        end

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule